// File: doc/BRIEF.md
# Wear-Leveling Reclaim and Allocation Selector

This block tracks the wear and the page occupancy of a small flash array and, on request, names two blocks: the block the garbage collector should reclaim next (the victim) and the fully free block that should take new data (the target). For every physical block it holds a saturating erase counter. For every page it holds one of three states: free, live or dead. Erase notifications, page-program notifications and page-invalidate notifications keep that state current. The block only decides. Copying data, issuing flash commands and translating addresses are left to the surrounding controller.

A select request starts a scan that visits one block per clock cycle. The victim side starts from a rotating victim index and the target side from its own rotating free index. Each side keeps the qualifying block with the smallest erase count, and on equal counts the first block reached wins. In dynamic mode only blocks that hold a dead page qualify as victims. In static mode any block with at least one programmed page qualifies, so cold blocks holding only live data can be cycled back into use. A programmable wear threshold keeps over-worn blocks out of reclaim while the array still has a reserve of two free blocks. When the reserve has run down, that exclusion is lifted so the reserve can be rebuilt. A one-cycle done pulse returns both results, each with a flag that says nothing qualified.

Top module: `wl_victim_sel`

## Requirements
- R1: After reset, done_o and busy_o are 0, free_cnt_o equals NUM_BLOCKS (every page free), victim_o is 0 and no_victim_o is 0.
- R2: Each erase notification raises that block's erase counter by one, and the counter holds at 2^CNT_W-1 instead of wrapping. victim_cnt_o reports the erase count of the chosen victim.
- R3: Page states are free, live and dead. Programming takes a free page to live and is ignored on a live or dead page. Invalidation takes a live page to dead and is ignored on a free or dead page. An erase returns every page of that block to free, and it takes priority over a program or invalidate aimed at the same block in the same cycle.
- R4: free_cnt_o is the number of blocks whose pages are all free, and it changes on the clock edge that applies the page update. It can rise only through an erase.
- R5: With sel_static_i = 0 (dynamic mode), only blocks holding at least one dead page are victim candidates.
- R6: With sel_static_i = 1 (static mode), every block with at least one live or dead page is a victim candidate.
- R7: The victim is the candidate with the lowest erase count. On equal counts, the first candidate reached going upward, with wrap-around, from the victim index wins. After a victim is found, the victim index moves to the block after it.
- R8: If free_cnt_o is at least 2 when a request is accepted, candidates whose erase count is greater than thresh_i are excluded. If it is below 2, no candidate is excluded by count.
- R9: The target is the all-free block with the lowest erase count. Ties are broken from the free index in the same way, and that index moves past the chosen target.
- R10: A request is accepted only while busy_o is 0. busy_o is then 1 for NUM_BLOCKS cycles, and done_o pulses for one cycle exactly NUM_BLOCKS cycles after the accepting edge. Requests made while busy_o is 1 are ignored. Results hold until the next done_o.
- R11: If no block qualifies as victim, no_victim_o is 1 together with done_o, victim_o and victim_cnt_o are 0, and the victim index is unchanged. If no block is all free, no_free_o is 1, free_blk_o is 0 and the free index is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| erase_i | input | 1 | A block was erased this cycle |
| erase_blk_i | input | BLK_W | Index of the erased block |
| prog_i | input | 1 | A page was programmed this cycle |
| prog_blk_i | input | BLK_W | Block of the programmed page |
| prog_page_i | input | PG_W | Page index within that block |
| inval_i | input | 1 | A page was invalidated this cycle |
| inval_blk_i | input | BLK_W | Block of the invalidated page |
| inval_page_i | input | PG_W | Page index within that block |
| sel_req_i | input | 1 | Start a selection scan |
| sel_static_i | input | 1 | 0 dynamic mode, 1 static mode |
| thresh_i | input | CNT_W | Wear threshold for reclaim exclusion |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle result strobe |
| victim_o | output | BLK_W | Chosen reclaim block |
| victim_cnt_o | output | CNT_W | Erase count of the chosen victim |
| no_victim_o | output | 1 | No victim candidate existed |
| free_blk_o | output | BLK_W | Chosen free target block |
| no_free_o | output | 1 | No all-free block existed |
| free_cnt_o | output | FCNT_W | Number of all-free blocks |

## Verification
Selection is first tried on an untouched array, which has no candidates and only equal-count free blocks. That separates the no-candidate path from the rotating tie-break of the target. A mixed array follows: dead-page blocks share an erase count and a live-only block is less worn, so repeated dynamic and static requests separate mode filtering, the least-count rule and the advance of the rotating index. The wear threshold is then applied with the free reserve intact and again with it exhausted, which shows whether exclusion depends on the reserve. Erasing one block hundreds of times tells saturation apart from wrap-around. Invalidating free pages and reprogramming dead pages, each observed through the free count and the next choice, shows that illegal page transitions are ignored.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    PG_FREE = 2'd0,
    PG_LIVE = 2'd1,
    PG_DEAD = 2'd2
  } pg_state_e;

  localparam int unsigned RESERVE_BLOCKS = 2;
endpackage

// File: rtl/wl_page_array.sv
module wl_page_array
  import wl_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS      = 16,
  parameter int unsigned PAGES_PER_BLOCK = 32,
  localparam int unsigned BLK_W = $clog2(NUM_BLOCKS),
  localparam int unsigned PG_W  = $clog2(PAGES_PER_BLOCK)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  erase_i,
  input  logic [BLK_W-1:0]      erase_blk_i,
  input  logic                  prog_i,
  input  logic [BLK_W-1:0]      prog_blk_i,
  input  logic [PG_W-1:0]       prog_page_i,
  input  logic                  inval_i,
  input  logic [BLK_W-1:0]      inval_blk_i,
  input  logic [PG_W-1:0]       inval_page_i,
  output logic [NUM_BLOCKS-1:0] blk_free_o,
  output logic [NUM_BLOCKS-1:0] blk_dead_o
);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [PAGES_PER_BLOCK-1:0] free_v;
    logic [PAGES_PER_BLOCK-1:0] dead_v;
    logic erase_hit, prog_blk_hit, inval_blk_hit;

    assign erase_hit     = erase_i && (erase_blk_i == BLK_W'(b));
    assign prog_blk_hit  = prog_i  && (prog_blk_i  == BLK_W'(b));
    assign inval_blk_hit = inval_i && (inval_blk_i == BLK_W'(b));

    for (genvar p = 0; p < PAGES_PER_BLOCK; p++) begin : g_pg
      pg_state_e st_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          st_q <= PG_FREE;
        end else if (erase_hit) begin
          st_q <= PG_FREE;
        end else if (prog_blk_hit && prog_page_i == PG_W'(p) && st_q == PG_FREE) begin
          st_q <= PG_LIVE;
        end else if (inval_blk_hit && inval_page_i == PG_W'(p) && st_q == PG_LIVE) begin
          st_q <= PG_DEAD;
        end
      end

      assign free_v[p] = (st_q == PG_FREE);
      assign dead_v[p] = (st_q == PG_DEAD);
    end

    assign blk_free_o[b] = &free_v;
    assign blk_dead_o[b] = |dead_v;
  end

endmodule

// File: rtl/wl_erase_cnt.sv
module wl_erase_cnt #(
  parameter int unsigned NUM_BLOCKS = 16,
  parameter int unsigned CNT_W      = 8,
  localparam int unsigned BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                erase_i,
  input  logic [BLK_W-1:0]                    erase_blk_i,
  output logic [NUM_BLOCKS-1:0][CNT_W-1:0]    cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (erase_i && erase_blk_i == BLK_W'(b) && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end

    assign cnt_o[b] = cnt_q;
  end

endmodule

// File: rtl/wl_scan.sv
module wl_scan
  import wl_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 16,
  parameter int unsigned CNT_W      = 8,
  localparam int unsigned BLK_W  = $clog2(NUM_BLOCKS),
  localparam int unsigned FCNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             sel_req_i,
  input  logic                             sel_static_i,
  input  logic [CNT_W-1:0]                 thresh_i,
  input  logic [FCNT_W-1:0]                free_cnt_i,
  input  logic [NUM_BLOCKS-1:0][CNT_W-1:0] blk_cnt_i,
  input  logic [NUM_BLOCKS-1:0]            blk_free_i,
  input  logic [NUM_BLOCKS-1:0]            blk_dead_i,
  output logic                             busy_o,
  output logic                             done_o,
  output logic [BLK_W-1:0]                 victim_o,
  output logic [CNT_W-1:0]                 victim_cnt_o,
  output logic                             no_victim_o,
  output logic [BLK_W-1:0]                 free_blk_o,
  output logic                             no_free_o
);

  localparam logic [BLK_W-1:0] LAST_IDX = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [BLK_W:0]   N_EXT    = (BLK_W+1)'(NUM_BLOCKS);

  logic             busy_q, done_q;
  logic [BLK_W-1:0] k_q, vptr_q, fptr_q;
  logic             static_q, rsv_ok_q;
  logic [CNT_W-1:0] thr_q;
  logic             v_found_q, f_found_q;
  logic [BLK_W-1:0] v_best_q, f_best_q;
  logic [CNT_W-1:0] v_bcnt_q, f_bcnt_q;
  logic [BLK_W-1:0] victim_q, free_blk_q;
  logic [CNT_W-1:0] victim_cnt_q;
  logic             no_victim_q, no_free_q;

  function automatic logic [BLK_W-1:0] ring_add(logic [BLK_W-1:0] base, logic [BLK_W-1:0] off);
    logic [BLK_W:0] s;
    s = {1'b0, base} + {1'b0, off};
    if (s >= N_EXT) s = s - N_EXT;
    return s[BLK_W-1:0];
  endfunction

  logic [BLK_W-1:0] v_blk, f_blk;
  logic [CNT_W-1:0] v_cnt, f_cnt;
  logic             v_cand, v_take, f_take;
  logic             nv_found, nf_found;
  logic [BLK_W-1:0] nv_best, nf_best;
  logic [CNT_W-1:0] nv_bcnt, nf_bcnt;
  logic [BLK_W-1:0] v_next, f_next;
  logic             last;

  always_comb begin
    v_blk  = ring_add(vptr_q, k_q);
    f_blk  = ring_add(fptr_q, k_q);
    v_cnt  = blk_cnt_i[v_blk];
    f_cnt  = blk_cnt_i[f_blk];
    v_cand = static_q ? !blk_free_i[v_blk] : blk_dead_i[v_blk];
    if (rsv_ok_q && v_cnt > thr_q) v_cand = 1'b0;
    // strict less-than keeps the first block reached on a tie
    v_take   = v_cand && (!v_found_q || v_cnt < v_bcnt_q);
    f_take   = blk_free_i[f_blk] && (!f_found_q || f_cnt < f_bcnt_q);
    nv_found = v_found_q | v_take;
    nv_best  = v_take ? v_blk : v_best_q;
    nv_bcnt  = v_take ? v_cnt : v_bcnt_q;
    nf_found = f_found_q | f_take;
    nf_best  = f_take ? f_blk : f_best_q;
    nf_bcnt  = f_take ? f_cnt : f_bcnt_q;
    v_next   = (nv_best == LAST_IDX) ? '0 : nv_best + BLK_W'(1);
    f_next   = (nf_best == LAST_IDX) ? '0 : nf_best + BLK_W'(1);
    last     = (k_q == LAST_IDX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      k_q          <= '0;
      vptr_q       <= '0;
      fptr_q       <= '0;
      static_q     <= 1'b0;
      rsv_ok_q     <= 1'b0;
      thr_q        <= '0;
      v_found_q    <= 1'b0;
      f_found_q    <= 1'b0;
      v_best_q     <= '0;
      f_best_q     <= '0;
      v_bcnt_q     <= '0;
      f_bcnt_q     <= '0;
      victim_q     <= '0;
      victim_cnt_q <= '0;
      no_victim_q  <= 1'b0;
      free_blk_q   <= '0;
      no_free_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (sel_req_i) begin
          busy_q    <= 1'b1;
          k_q       <= '0;
          static_q  <= sel_static_i;
          thr_q     <= thresh_i;
          rsv_ok_q  <= (free_cnt_i >= FCNT_W'(RESERVE_BLOCKS));
          v_found_q <= 1'b0;
          f_found_q <= 1'b0;
        end
      end else begin
        k_q       <= k_q + BLK_W'(1);
        v_found_q <= nv_found;
        v_best_q  <= nv_best;
        v_bcnt_q  <= nv_bcnt;
        f_found_q <= nf_found;
        f_best_q  <= nf_best;
        f_bcnt_q  <= nf_bcnt;
        if (last) begin
          busy_q       <= 1'b0;
          done_q       <= 1'b1;
          victim_q     <= nv_found ? nv_best : '0;
          victim_cnt_q <= nv_found ? nv_bcnt : '0;
          no_victim_q  <= !nv_found;
          free_blk_q   <= nf_found ? nf_best : '0;
          no_free_q    <= !nf_found;
          if (nv_found) vptr_q <= v_next;
          if (nf_found) fptr_q <= f_next;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign victim_o     = victim_q;
  assign victim_cnt_o = victim_cnt_q;
  assign no_victim_o  = no_victim_q;
  assign free_blk_o   = free_blk_q;
  assign no_free_o    = no_free_q;

endmodule

// File: rtl/wl_victim_sel.sv
module wl_victim_sel #(
  parameter int unsigned NUM_BLOCKS      = 16,
  parameter int unsigned PAGES_PER_BLOCK = 32,
  parameter int unsigned CNT_W           = 8,
  localparam int unsigned BLK_W  = $clog2(NUM_BLOCKS),
  localparam int unsigned PG_W   = $clog2(PAGES_PER_BLOCK),
  localparam int unsigned FCNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic [BLK_W-1:0]  erase_blk_i,
  input  logic              prog_i,
  input  logic [BLK_W-1:0]  prog_blk_i,
  input  logic [PG_W-1:0]   prog_page_i,
  input  logic              inval_i,
  input  logic [BLK_W-1:0]  inval_blk_i,
  input  logic [PG_W-1:0]   inval_page_i,
  input  logic              sel_req_i,
  input  logic              sel_static_i,
  input  logic [CNT_W-1:0]  thresh_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BLK_W-1:0]  victim_o,
  output logic [CNT_W-1:0]  victim_cnt_o,
  output logic              no_victim_o,
  output logic [BLK_W-1:0]  free_blk_o,
  output logic              no_free_o,
  output logic [FCNT_W-1:0] free_cnt_o
);

  logic [NUM_BLOCKS-1:0]            blk_free, blk_dead;
  logic [NUM_BLOCKS-1:0][CNT_W-1:0] blk_cnt;
  logic [FCNT_W-1:0]                free_cnt;

  wl_page_array #(
    .NUM_BLOCKS     (NUM_BLOCKS),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
  ) i_pages (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .erase_i     (erase_i),
    .erase_blk_i (erase_blk_i),
    .prog_i      (prog_i),
    .prog_blk_i  (prog_blk_i),
    .prog_page_i (prog_page_i),
    .inval_i     (inval_i),
    .inval_blk_i (inval_blk_i),
    .inval_page_i(inval_page_i),
    .blk_free_o  (blk_free),
    .blk_dead_o  (blk_dead)
  );

  wl_erase_cnt #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .CNT_W     (CNT_W)
  ) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .erase_i    (erase_i),
    .erase_blk_i(erase_blk_i),
    .cnt_o      (blk_cnt)
  );

  always_comb begin
    free_cnt = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) free_cnt = free_cnt + FCNT_W'(blk_free[b]);
  end

  wl_scan #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .CNT_W     (CNT_W)
  ) i_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_req_i   (sel_req_i),
    .sel_static_i(sel_static_i),
    .thresh_i    (thresh_i),
    .free_cnt_i  (free_cnt),
    .blk_cnt_i   (blk_cnt),
    .blk_free_i  (blk_free),
    .blk_dead_i  (blk_dead),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .victim_o    (victim_o),
    .victim_cnt_o(victim_cnt_o),
    .no_victim_o (no_victim_o),
    .free_blk_o  (free_blk_o),
    .no_free_o   (no_free_o)
  );

  assign free_cnt_o = free_cnt;

endmodule

// File: rtl/wl_victim_sel_chk.sv
module wl_victim_sel_chk #(
  parameter int unsigned NUM_BLOCKS = 16,
  parameter int unsigned CNT_W      = 8,
  localparam int unsigned BLK_W  = $clog2(NUM_BLOCKS),
  localparam int unsigned FCNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             erase_i,
  input logic [BLK_W-1:0]                 erase_blk_i,
  input logic                             prog_i,
  input logic                             busy_o,
  input logic                             done_o,
  input logic [BLK_W-1:0]                 victim_o,
  input logic [CNT_W-1:0]                 victim_cnt_o,
  input logic                             no_victim_o,
  input logic [BLK_W-1:0]                 free_blk_o,
  input logic                             no_free_o,
  input logic [FCNT_W-1:0]                free_cnt_o,
  input logic [NUM_BLOCKS-1:0][CNT_W-1:0] blk_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assert_cnt_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (erase_i && erase_blk_i == BLK_W'(b) && blk_cnt[b] != CNT_MAX)
        |=> blk_cnt[b] == $past(blk_cnt[b]) + CNT_W'(1));
    assert_cnt_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (erase_i && erase_blk_i == BLK_W'(b) && blk_cnt[b] == CNT_MAX)
        |=> blk_cnt[b] == CNT_MAX);
    assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(erase_i && erase_blk_i == BLK_W'(b)) |=> $stable(blk_cnt[b]));
  end

  assert_free_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_i |=> free_cnt_o <= $past(free_cnt_o));
  assert_free_erase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_i && !prog_i) |=> free_cnt_o >= $past(free_cnt_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || ($stable(victim_o) && $stable(free_blk_o) && $stable(no_victim_o))));

  assert_no_victim_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && no_victim_o) |-> (victim_o == '0 && victim_cnt_o == '0));
  assert_no_free_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && no_free_o) |-> free_blk_o == '0);

endmodule

bind wl_victim_sel wl_victim_sel_chk #(
  .NUM_BLOCKS(NUM_BLOCKS),
  .CNT_W     (CNT_W)
) i_wl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .erase_i     (erase_i),
  .erase_blk_i (erase_blk_i),
  .prog_i      (prog_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .victim_o    (victim_o),
  .victim_cnt_o(victim_cnt_o),
  .no_victim_o (no_victim_o),
  .free_blk_o  (free_blk_o),
  .no_free_o   (no_free_o),
  .free_cnt_o  (free_cnt_o),
  .blk_cnt     (blk_cnt)
);

// File: tb/test_wl_victim_sel.sv
module test_wl_victim_sel;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NB = 16;
  localparam int NP = 32;
  localparam int CW = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       erase_i = 1'b0, prog_i = 1'b0, inval_i = 1'b0;
  logic [3:0] erase_blk_i = '0, prog_blk_i = '0, inval_blk_i = '0;
  logic [4:0] prog_page_i = '0, inval_page_i = '0;
  logic       sel_req_i = 1'b0, sel_static_i = 1'b0;
  logic [7:0] thresh_i = '0;
  logic       busy_o, done_o, no_victim_o, no_free_o;
  logic [3:0] victim_o, free_blk_o;
  logic [7:0] victim_cnt_o;
  logic [4:0] free_cnt_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  wl_victim_sel #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(NP), .CNT_W(CW)) i_wl_victim_sel (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_erase(input int b);
    @(negedge clk_i); erase_i = 1'b1; erase_blk_i = 4'(b);
    @(negedge clk_i); erase_i = 1'b0;
  endtask

  task automatic do_prog(input int b, input int p);
    @(negedge clk_i); prog_i = 1'b1; prog_blk_i = 4'(b); prog_page_i = 5'(p);
    @(negedge clk_i); prog_i = 1'b0;
  endtask

  task automatic do_inval(input int b, input int p);
    @(negedge clk_i); inval_i = 1'b1; inval_blk_i = 4'(b); inval_page_i = 5'(p);
    @(negedge clk_i); inval_i = 1'b0;
  endtask

  // request, wait for done, check latency (R10) and single-cycle strobe
  task automatic do_sel(input logic st, input logic [7:0] thr);
    int lat;
    @(negedge clk_i); sel_req_i = 1'b1; sel_static_i = st; thresh_i = thr;
    @(negedge clk_i); sel_req_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk_i); lat++;
    end
    chk(lat == NB, "R10 latency", lat, NB);
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  typedef struct packed {
    logic       st;
    logic [7:0] thr;
    logic       nv;
    logic [3:0] v;
    logic [7:0] vc;
    logic [3:0] f;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 8'd255, 1'b0, 4'd5,  8'd2, 4'd3},
    '{1'b0, 8'd255, 1'b0, 4'd9,  8'd2, 4'd4},
    '{1'b0, 8'd255, 1'b0, 4'd5,  8'd2, 4'd6},
    '{1'b1, 8'd255, 1'b0, 4'd12, 8'd0, 4'd7},
    '{1'b1, 8'd255, 1'b0, 4'd12, 8'd0, 4'd8},
    '{1'b0, 8'd1,   1'b1, 4'd0,  8'd0, 4'd10},
    '{1'b0, 8'd2,   1'b0, 4'd5,  8'd2, 4'd11}
  };

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
    chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
    chk(free_cnt_o == 5'(NB), "R1 free_cnt", int'(free_cnt_o), NB);
    chk(victim_o == 4'd0 && no_victim_o == 1'b0, "R1 victim", int'(victim_o), 0);

    // empty array: no victim, free tie from index 0
    do_sel(1'b0, 8'd255);
    chk(no_victim_o == 1'b1, "R11 no victim empty", int'(no_victim_o), 1);
    chk(victim_o == 4'd0, "R11 victim zero", int'(victim_o), 0);
    chk(free_blk_o == 4'd0 && no_free_o == 1'b0, "R9 first free", int'(free_blk_o), 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R10 done one cycle", int'(done_o), 0);
    do_sel(1'b0, 8'd255);
    chk(free_blk_o == 4'd1, "R9 free rotates", int'(free_blk_o), 1);

    // wear and occupancy setup
    do_erase(0); do_erase(1); do_erase(2);
    do_erase(5); do_erase(5); do_erase(9); do_erase(9);
    chk(free_cnt_o == 5'd16, "R4 erase keeps free", int'(free_cnt_o), 16);
    do_prog(2, 0);
    chk(free_cnt_o == 5'd15, "R4 program drops free", int'(free_cnt_o), 15);
    do_prog(5, 0); do_inval(5, 0);
    do_prog(9, 3); do_inval(9, 3);
    do_prog(12, 1);
    chk(free_cnt_o == 5'd12, "R4 free count", int'(free_cnt_o), 12);

    // R3 illegal transitions are ignored
    do_inval(3, 4);
    chk(free_cnt_o == 5'd12, "R3 invalidate free page ignored", int'(free_cnt_o), 12);
    do_inval(12, 2);
    do_prog(5, 0);

    // vector table: modes, least count, ties, rotation, threshold
    foreach (VECS[i]) begin
      do_sel(VECS[i].st, VECS[i].thr);
      chk(no_victim_o == VECS[i].nv, "R5 R6 R8 no_victim", int'(no_victim_o), int'(VECS[i].nv));
      chk(victim_o == VECS[i].v, "R5 R6 R7 victim", int'(victim_o), int'(VECS[i].v));
      chk(victim_cnt_o == VECS[i].vc, "R7 victim count", int'(victim_cnt_o), int'(VECS[i].vc));
      chk(free_blk_o == VECS[i].f, "R9 free target", int'(free_blk_o), int'(VECS[i].f));
    end

    // exhaust the free reserve: threshold exclusion lifted
    foreach (VECS[i]) begin end
    for (int b = 0; b < 15; b++) begin
      if (b != 2 && b != 5 && b != 9 && b != 12) do_prog(b, 0);
    end
    chk(free_cnt_o == 5'd1, "R4 one free left", int'(free_cnt_o), 1);
    do_sel(1'b0, 8'd1);
    chk(no_victim_o == 1'b0 && victim_o == 4'd9, "R8 reserve low picks worn", int'(victim_o), 9);
    chk(free_blk_o == 4'd15, "R9 last free", int'(free_blk_o), 15);

    do_prog(15, 0);
    chk(free_cnt_o == 5'd0, "R4 none free", int'(free_cnt_o), 0);
    do_sel(1'b1, 8'd255);
    chk(victim_o == 4'd10 && victim_cnt_o == 8'd0, "R6 static live-only victim", int'(victim_o), 10);
    chk(no_free_o == 1'b1 && free_blk_o == 4'd0, "R11 no free", int'(free_blk_o), 0);

    // R10 request while busy is ignored
    @(negedge clk_i); sel_req_i = 1'b1; sel_static_i = 1'b1; thresh_i = 8'd255;
    @(negedge clk_i); sel_req_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy during scan", int'(busy_o), 1);
    repeat (3) @(negedge clk_i);
    sel_req_i = 1'b1;
    @(negedge clk_i); sel_req_i = 1'b0;
    begin
      int dones = 0;
      for (int c = 0; c < 3 * NB; c++) begin
        @(negedge clk_i);
        if (done_o) dones++;
      end
      chk(dones == 1, "R10 busy request ignored", dones, 1);
      chk(busy_o == 1'b0, "R10 idle after scan", int'(busy_o), 0);
    end

    // R3 erase clears a block
    do_erase(5);
    chk(free_cnt_o == 5'd1, "R3 erase frees block", int'(free_cnt_o), 1);

    // R2 increment and saturation
    do_reset();
    chk(free_cnt_o == 5'(NB), "R1 free after reset", int'(free_cnt_o), NB);
    for (int n = 0; n < 300; n++) do_erase(0);
    do_prog(0, 0);
    do_sel(1'b1, 8'd255);
    chk(victim_o == 4'd0 && victim_cnt_o == 8'd255, "R2 counter saturates", int'(victim_cnt_o), 255);
    for (int n = 0; n < 7; n++) do_erase(3);
    do_prog(3, 0);
    do_sel(1'b1, 8'd255);
    chk(victim_o == 4'd3 && victim_cnt_o == 8'd7, "R2 counter increments", int'(victim_cnt_o), 7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule